// File: doc/BRIEF.md
# Function Level Reset Controller

This block gives one bus-attached peripheral function a soft reset that software can start on its own, without a platform-wide reset. Software sets a control bit through a small register port. From then on, the block refuses every new request aimed at the function. Each refused request gets an immediate abort response in the same cycle, while completions returning to the function are still accepted. The block then holds a reset line into the function core for a fixed number of clock cycles. During that time the function's register file goes back to its default contents. Registers named in an exempt mask keep their values.

Once the reset line has dropped, the block spends one more cycle in a closing state. It then clears the control bit, and software polls that bit to see that the reset is over. The same register port also reaches the function's own registers. Software is expected to wait at least 100 ms after setting the bit before it touches the function again. The hold length here is a parameter with a small default, so the behaviour can be exercised quickly.

Top module: `flr_ctrl`

## Requirements
- R1: A write to address 0 with data bit 0 equal to 1, made while the block is idle, starts a reset; from the next cycle address 0 reads back bit 0 = 1.
- R2: The function reset output `core_rst` is high for exactly HOLD_CYCLES consecutive cycles, beginning in the cycle after the starting write.
- R3: After `core_rst` falls, the control bit stays 1 for one more cycle and then reads 0; the reset line is always released before the bit clears.
- R4: While the control bit reads 1, a request (`req_valid` = 1) is not claimed and `req_abort` is 1 in the same cycle as the request.
- R5: While the control bit reads 0, a request is claimed (`req_claim` = 1) in the same cycle and `req_abort` stays 0; with no request, neither output is 1.
- R6: `cpl_accept` equals `cpl_valid` in every cycle, whether or not a reset is running.
- R7: After a reset, every function register whose EXEMPT_MASK bit is 0 holds its default value, which is 8'h5A plus 8'h11 times its index (index k sits at address k+1).
- R8: A function register whose EXEMPT_MASK bit is 1 keeps the value it held before the reset.
- R9: Writing address 0 with data bit 0 equal to 0 has no effect. Writing 1 while the control bit reads 1 does not lengthen or restart the running reset.
- R10: Writes to function registers are dropped while the control bit reads 1, exempt registers included.
- R11: After the port reset `rst_n`, the block is idle, `core_rst` is 0, the control bit reads 0 and every function register holds its default value.
- R12: The register map is as follows. Address 0 returns the control bit in bit 0 and zeros in the other bits. Addresses 1..NUM_REGS read and write function registers 0..NUM_REGS-1. Any higher address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous port reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for `reg_addr`, combinational |
| req_valid | input | 1 | New configuration, I/O or memory request targets the function |
| req_claim | output | 1 | Request claimed this cycle |
| req_abort | output | 1 | Immediate master-abort pulse for an unclaimed request |
| cpl_valid | input | 1 | Completion arriving for the function |
| cpl_accept | output | 1 | Completion accepted |
| core_rst | output | 1 | Reset held into the function core |

## Verification
A wrong internal sequencer state shows up at the ports in the cycle it occurs. A stuck or miscounted hold counter changes the number of cycles `core_rst` stays high. A skipped closing state makes the control bit fall in the same cycle as the reset line. Either fault flips `req_claim` and `req_abort` for any request presented in that cycle. A wrong exempt or default decision in the register file is not visible at once. It appears on the first read of that address after the reset ends, so the bench reads every function register back after each reset, and it also reads the control bit while the reset is running.

// File: rtl/flr_pkg.sv
package flr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_RESETTING = 2'd1,
    ST_DONE      = 2'd2
  } flr_state_e;

  // Default contents of function register idx (truncated by the caller).
  function automatic logic [31:0] fn_reg_default(input int unsigned idx);
    return 32'h5A + idx * 32'h11;
  endfunction

  // True when addr selects a function register (addresses 1..num_regs).
  function automatic logic fn_in_window(input int unsigned addr, input int unsigned num_regs);
    return (addr >= 1) && (addr <= num_regs);
  endfunction

endpackage

// File: rtl/flr_seq.sv
module flr_seq
  import flr_pkg::*;
#(
  parameter int HOLD_CYCLES = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  output flr_state_e state,
  output logic       core_rst,
  output logic       busy
);
  localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  flr_state_e    state_q;
  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      hold_cnt <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_req) begin
            state_q  <= ST_RESETTING;
            hold_cnt <= '0;
          end
        end
        ST_RESETTING: begin
          if (hold_cnt == LAST) state_q <= ST_DONE;
          else hold_cnt <= hold_cnt + 1'b1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state    = state_q;
  assign core_rst = (state_q == ST_RESETTING);
  assign busy     = (state_q != ST_IDLE);

  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_req) |=> (state_q == ST_RESETTING && hold_cnt == '0));

  assert_hold_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESETTING && hold_cnt == LAST) |=> (state_q == ST_DONE));

  assert_release_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> busy);

  assert_done_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));

  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> !(state_q == ST_RESETTING && hold_cnt == '0));

endmodule

// File: rtl/flr_req_gate.sv
module flr_req_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic blocked,
  input  logic req_valid,
  input  logic cpl_valid,
  output logic req_claim,
  output logic req_abort,
  output logic cpl_accept
);
  always_comb begin
    req_claim  = 1'b0;
    req_abort  = 1'b0;
    if (req_valid) begin
      if (blocked) req_abort = 1'b1;
      else         req_claim = 1'b1;
    end
    cpl_accept = cpl_valid;
  end

  assert_blocked_no_claim_R4: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> !req_claim);

  assert_abort_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_abort |-> (req_valid && blocked));

  assert_open_claims_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !blocked) |-> (req_claim && !req_abort));

  assert_cpl_always_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> cpl_accept);

endmodule

// File: rtl/flr_regfile.sv
module flr_regfile
  import flr_pkg::*;
#(
  parameter int                    NUM_REGS    = 4,
  parameter int                    REG_W       = 8,
  parameter logic [NUM_REGS-1:0]   EXEMPT_MASK = '0,
  localparam int                   IW          = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            core_rst,
  input  logic                            wr_en,
  input  logic [IW-1:0]                   wr_idx,
  input  logic [REG_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][REG_W-1:0]  regs_q
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [REG_W-1:0] DEF = REG_W'(fn_reg_default(g));
    localparam bit KEEP = EXEMPT_MASK[g];

    always_ff @(posedge clk) begin
      if (!rst_n)                              regs_q[g] <= DEF;
      else if (core_rst && !KEEP)              regs_q[g] <= DEF;
      else if (wr_en && wr_idx == IW'(g))      regs_q[g] <= wr_data;
    end

    if (KEEP) begin : g_keep
      assert_exempt_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> $stable(regs_q[g]));
    end else begin : g_clear
      assert_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> (regs_q[g] == DEF));
    end
  end

endmodule

// File: rtl/flr_ctrl.sv
module flr_ctrl
  import flr_pkg::*;
#(
  parameter int                  NUM_REGS    = 4,
  parameter int                  REG_W       = 8,
  parameter int                  HOLD_CYCLES = 6,
  parameter logic [NUM_REGS-1:0] EXEMPT_MASK = 4'b0101,
  localparam int                 ADDR_W      = $clog2(NUM_REGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              req_valid,
  output logic              req_claim,
  output logic              req_abort,
  input  logic              cpl_valid,
  output logic              cpl_accept,
  output logic              core_rst
);
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  flr_state_e                      state;
  logic                            busy;
  logic                            wr_ok;
  logic                            start_req;
  logic                            fn_hit;
  logic                            fn_wr;
  logic [IW-1:0]                   fn_idx;
  logic [NUM_REGS-1:0][REG_W-1:0]  regs_q;

  // Named decode events
  assign wr_ok     = reg_wr_en && !busy;
  assign fn_hit    = fn_in_window(32'(reg_addr), NUM_REGS);
  assign fn_idx    = IW'(reg_addr - ADDR_W'(1));
  assign start_req = wr_ok && (reg_addr == '0) && reg_wdata[0];
  assign fn_wr     = wr_ok && fn_hit;

  flr_seq #(.HOLD_CYCLES(HOLD_CYCLES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_req(start_req),
    .state    (state),
    .core_rst (core_rst),
    .busy     (busy)
  );

  flr_req_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .blocked   (busy),
    .req_valid (req_valid),
    .cpl_valid (cpl_valid),
    .req_claim (req_claim),
    .req_abort (req_abort),
    .cpl_accept(cpl_accept)
  );

  flr_regfile #(
    .NUM_REGS   (NUM_REGS),
    .REG_W      (REG_W),
    .EXEMPT_MASK(EXEMPT_MASK)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .core_rst(core_rst),
    .wr_en   (fn_wr),
    .wr_idx  (fn_idx),
    .wr_data (reg_wdata),
    .regs_q  (regs_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata[0] = busy;
    else if (fn_hit)    reg_rdata    = regs_q[fn_idx];
  end

  assert_busy_drops_writes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fn_wr);

  assert_bit_reads_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == '0) |-> (reg_rdata[REG_W-1:1] == '0));

  assert_done_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |-> (!core_rst && reg_addr != '0 || reg_rdata[0] || reg_addr != '0));

endmodule

// File: tb/flr_ctrl_tb.sv
`timescale 1ns/1ps
module flr_ctrl_tb;
  localparam int NR   = 4;
  localparam int RW   = 8;
  localparam int HOLD = 6;
  localparam logic [NR-1:0] EXM = 4'b0101;
  localparam int AW   = $clog2(NR + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [RW-1:0] wdata = '0;
  logic          req = 1'b0;
  logic          cpl = 1'b0;
  logic [RW-1:0] rdata;
  logic          claim, abort_o, cpl_acc, core_rst;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  flr_ctrl #(.NUM_REGS(NR), .REG_W(RW), .HOLD_CYCLES(HOLD), .EXEMPT_MASK(EXM)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .req_valid(req), .req_claim(claim), .req_abort(abort_o),
    .cpl_valid(cpl), .cpl_accept(cpl_acc), .core_rst(core_rst)
  );

  // Default value: start at 5A, add 11 per index
  function automatic logic [RW-1:0] dflt(int k);
    logic [RW-1:0] v = 8'h5A;
    for (int j = 0; j < k; j++) v = v + 8'h11;
    return v;
  endfunction

  // Behavioural reference: cycles of busy left (reset phase + closing cycle)
  int            m_left;
  logic [RW-1:0] m_regs [NR];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0;
      for (int k = 0; k < NR; k++) m_regs[k] = dflt(k);
    end else if (m_left > 0) begin
      if (m_left > 1)
        for (int k = 0; k < NR; k++) if (!EXM[k]) m_regs[k] = dflt(k);
      m_left = m_left - 1;
    end else if (wr) begin
      if (addr == 0) begin
        if (wdata[0]) m_left = HOLD + 1;
      end else if (int'(addr) <= NR) begin
        m_regs[int'(addr) - 1] = wdata;
      end
    end
  end

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    logic [RW-1:0] er;
    bit bz;
    bz = (m_left > 0);
    er = '0;
    if (addr == 0) er[0] = bz;
    else if (int'(addr) <= NR) er = m_regs[int'(addr) - 1];
    cmp("R2 core_rst", core_rst, m_left > 1);
    cmp("R4 req_abort", abort_o, req && bz);
    cmp("R5 req_claim", claim, req && !bz);
    cmp("R6 cpl_accept", cpl_acc, cpl);
    if (addr == 0) cmp("R3 control bit", rdata, er);
    else           cmp("R12 rdata", rdata, er);
  endtask

  task automatic step(logic w, int a, logic [RW-1:0] d, logic rq, logic cp);
    @(negedge clk);
    wr = w; addr = AW'(a); wdata = d; req = rq; cpl = cp;
    #5;
    if (rst_n) cmp_all();
  endtask

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int rst_cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: state after port reset
    step(0, 0, 0, 0, 0);
    cmp("R11 idle core_rst", core_rst, 0);
    cmp("R11 idle bit", rdata, 0);
    step(0, 3, 0, 0, 0);
    cmp("R11 reg default", rdata, dflt(2));

    // R12: fill function registers and read every address
    for (int k = 1; k <= NR; k++) step(1, k, 8'hC0 + RW'(k), 0, 0);
    for (int k = 0; k < 8; k++) step(0, k, 0, k[0], k[1]);
    step(1, 6, 8'hFF, 1, 1);
    step(0, 6, 0, 1, 0);
    cmp("R12 out of range", rdata, 0);

    // R9: writing 0 to the control bit has no effect
    step(1, 0, 8'hFE, 0, 0);
    step(0, 0, 0, 1, 0);
    cmp("R9 write zero", rdata, 0);
    cmp("R9 write zero claim", claim, 1);

    // R1: start a reset
    step(1, 0, 8'h01, 0, 0);
    step(0, 0, 0, 1, 1);
    cmp("R1 bit set", rdata, 1);
    cmp("R1 core_rst", core_rst, 1);
    step(1, 0, 8'h01, 1, 0);           // R9: restart attempt ignored
    step(1, 1, 8'h33, 0, 1);           // R10: exempt write dropped
    step(1, 2, 8'h44, 1, 1);
    for (int k = 0; k < 6; k++) step(0, k % 5, 0, 1, k[0]);
    for (int k = 0; k < 3; k++) step(0, 0, 0, 1, 0);
    cmp("R9 no extension", rdata, 0);

    // R7, R8, R10: register contents after the reset
    step(0, 1, 0, 0, 0);
    cmp("R10 R8 exempt reg0", rdata, 8'hC1);
    step(0, 2, 0, 0, 0);
    cmp("R7 reg1 default", rdata, dflt(1));
    step(0, 3, 0, 0, 0);
    cmp("R8 exempt reg2", rdata, 8'hC3);
    step(0, 4, 0, 0, 0);
    cmp("R7 reg3 default", rdata, dflt(3));

    // Second reset: count core_rst cycles (R2), then start during closing cycle
    for (int k = 1; k <= NR; k++) step(1, k, 8'h90 + RW'(k), 0, 0);
    step(1, 0, 8'hFF, 0, 0);
    rst_cnt = 0;
    for (int k = 0; k < HOLD; k++) begin
      step(0, k % 5, 0, 1, 1);
      if (core_rst) rst_cnt++;
    end
    step(1, 0, 8'h01, 1, 0);           // closing cycle: ignored (R9)
    cmp("R3 released before clear", core_rst, 0);
    step(0, 0, 0, 1, 0);
    cmp("R3 bit cleared", rdata, 0);
    cmp("R2 hold length", rst_cnt, HOLD);
    for (int k = 1; k <= NR; k++) step(0, k, 0, 0, 0);

    // Back-to-back reset straight from idle
    step(1, 0, 8'h01, 0, 0);
    for (int k = 0; k < HOLD + 4; k++) step(k == 2, k % 5, 8'h77, k[0], !k[0]);
    for (int k = 0; k <= NR; k++) step(0, k, 0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule